// File: doc/BRIEF.md
# Tree-Structured Carry Look-Ahead Adder

This block adds two 8-bit operands and a carry input in pure combinational logic, with a carry path whose depth grows with the logarithm of the width rather than linearly. Each bit position first classifies itself as generating a carry (both operand bits set) or passing one along (exactly one operand bit set). These per-bit terms are merged pairwise up a binary tree: pairs of bits, then groups of four, then the whole word. Every merge node and every carry tap is built only from two-input gates.

Each internal carry is taken from the tree node whose span ends just below that bit, combined with the carry that enters that span: a group carry equals the group's generate term OR (its propagate term AND its incoming carry). Bits with an odd index get their carry from a single-bit node, bits 2 and 6 from pair nodes, bit 4 from the lower four-bit group, and the final carry from the root node applied to the carry input. The sum bit is the propagate term XOR the carry into that bit.

The root's group propagate and group generate are brought out so that a second-level look-ahead unit can combine several copies of this adder into a wider one. The width is a parameter that must be a power of two; the default is 8.

Top module: `lookahead_adder`

## Requirements
- R1: `sum` equals the low WIDTH bits of `op_a + op_b + carry_in`.
- R2: `carry_out` equals bit WIDTH of `op_a + op_b + carry_in` (1 when the full result exceeds 2^WIDTH - 1).
- R3: `grp_prop` is 1 exactly when `op_a XOR op_b` has every bit set.
- R4: `grp_gen` is 1 exactly when `op_a + op_b` with no carry input produces a carry out of the top bit.
- R5: `carry_out` equals `grp_gen OR (grp_prop AND carry_in)` for every input, so the group terms can drive an outer look-ahead stage.
- R6: `grp_gen` and `grp_prop` are never 1 at the same time.
- R7: The carry into each bit position j (1 to WIDTH) equals the carry out of the sum of the low j bits of both operands plus `carry_in`; a carry entering at `carry_in` travels through exactly as many all-propagate bits as there are.
- R8: For each bit, the generate term (`op_a` bit AND `op_b` bit) and the propagate term (`op_a` bit XOR `op_b` bit) are never both 1; when both are 0 the bit kills any incoming carry.
- R9: The block holds no state: outputs follow inputs within the same clock cycle, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of the result |
| carry_out | output | 1 | Carry out of the top bit |
| grp_prop | output | 1 | Whole-word propagate term, for cascading |
| grp_gen | output | 1 | Whole-word generate term, for cascading |

## Verification
Every result of this adder is due in the same cycle as its stimulus, after only gate delay: there are no registers between any input and `sum`, `carry_out`, `grp_prop` or `grp_gen`. The bench therefore changes the operands just after a rising clock edge and samples all four outputs at the following falling edge, half a period later, so nothing is read while inputs are moving. One directed case changes the operands away from any edge and samples one time unit later, showing that no clock edge is needed for the result. The sweep over all 2^17 operand and carry combinations runs one combination per cycle under the same drive-then-sample rule.

// File: rtl/lookahead_adder_pkg.sv
package lookahead_adder_pkg;

  // Generate / propagate pair carried by every tree node.
  typedef struct packed {
    logic g;
    logic p;
  } pg_t;

  // Per-bit classification from one bit of each operand.
  function automatic pg_t bit_classify(input logic a_bit, input logic b_bit);
    pg_t r;
    r.g = a_bit & b_bit;
    r.p = a_bit ^ b_bit;
    return r;
  endfunction

  // Merge two adjacent spans: hi sits above lo. Two-input gates only.
  function automatic pg_t pg_merge(input pg_t hi, input pg_t lo);
    pg_t r;
    logic pass_lo;
    pass_lo = hi.p & lo.g;
    r.g     = hi.g | pass_lo;
    r.p     = hi.p & lo.p;
    return r;
  endfunction

  // Carry leaving a span given the carry entering it.
  function automatic logic carry_through(input pg_t span, input logic cin);
    logic pass_in;
    pass_in = span.p & cin;
    return span.g | pass_in;
  endfunction

  // Index of the lowest set bit of v (0 when v is zero).
  function automatic int lowest_set(input int v);
    int r;
    r = 0;
    for (int i = 30; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  // Offset of tree level lvl inside the flat node array.
  function automatic int level_base(input int width, input int lvl);
    return 2 * width - ((2 * width) >> lvl);
  endfunction

endpackage

// File: rtl/lookahead_bit_cell.sv
module lookahead_bit_cell
  import lookahead_adder_pkg::*;
(
  input  logic a_bit,
  input  logic b_bit,
  output logic gen_o,
  output logic prop_o
);

  pg_t cls;

  always_comb begin
    cls    = bit_classify(a_bit, b_bit);
    gen_o  = cls.g;
    prop_o = cls.p;
  end

endmodule

// File: rtl/lookahead_pg_node.sv
module lookahead_pg_node
  import lookahead_adder_pkg::*;
(
  input  logic hi_g,
  input  logic hi_p,
  input  logic lo_g,
  input  logic lo_p,
  output logic out_g,
  output logic out_p
);

  pg_t merged;

  always_comb begin
    merged = pg_merge('{g: hi_g, p: hi_p}, '{g: lo_g, p: lo_p});
    out_g  = merged.g;
    out_p  = merged.p;
  end

endmodule

// File: rtl/lookahead_carry_tap.sv
module lookahead_carry_tap
  import lookahead_adder_pkg::*;
(
  input  logic span_g,
  input  logic span_p,
  input  logic cin,
  output logic cout
);

  always_comb begin
    cout = carry_through('{g: span_g, p: span_p}, cin);
  end

endmodule

// File: rtl/lookahead_adder.sv
module lookahead_adder
  import lookahead_adder_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             grp_prop,
  output logic             grp_gen
);

  localparam int LEVELS = $clog2(WIDTH);
  localparam int NODES  = 2 * WIDTH - 1;
  localparam int ROOT   = NODES - 1;

  // Named internal events, brought out for the checker.
  logic [WIDTH-1:0] bit_g;
  logic [WIDTH-1:0] bit_p;
  logic [NODES-1:0] node_g;
  logic [NODES-1:0] node_p;
  logic [WIDTH:0]   carry_w;

  // Level 0: one classifier per bit.
  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    lookahead_bit_cell u_cell (
      .a_bit (op_a[i]),
      .b_bit (op_b[i]),
      .gen_o (bit_g[i]),
      .prop_o(bit_p[i])
    );
    assign node_g[i] = bit_g[i];
    assign node_p[i] = bit_p[i];
  end

  // Levels 1..LEVELS: pairwise merge nodes.
  for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
    localparam int BASE_HERE  = level_base(WIDTH, l);
    localparam int BASE_BELOW = level_base(WIDTH, l - 1);
    for (genvar n = 0; n < (WIDTH >> l); n++) begin : g_node
      lookahead_pg_node u_node (
        .hi_g (node_g[BASE_BELOW + 2*n + 1]),
        .hi_p (node_p[BASE_BELOW + 2*n + 1]),
        .lo_g (node_g[BASE_BELOW + 2*n]),
        .lo_p (node_p[BASE_BELOW + 2*n]),
        .out_g(node_g[BASE_HERE + n]),
        .out_p(node_p[BASE_HERE + n])
      );
    end
  end

  // Carry taps: carry into bit j uses the aligned node of size 2^t ending
  // at bit j-1, where t is the lowest set bit of j.
  assign carry_w[0] = carry_in;
  for (genvar j = 1; j <= WIDTH; j++) begin : g_tap
    localparam int T    = lowest_set(j);
    localparam int IDX  = level_base(WIDTH, T) + (j >> T) - 1;
    localparam int SRC  = j - (1 << T);
    lookahead_carry_tap u_tap (
      .span_g(node_g[IDX]),
      .span_p(node_p[IDX]),
      .cin   (carry_w[SRC]),
      .cout  (carry_w[j])
    );
  end

  assign sum       = bit_p ^ carry_w[WIDTH-1:0];
  assign carry_out = carry_w[WIDTH];
  assign grp_prop  = node_p[ROOT];
  assign grp_gen   = node_g[ROOT];

endmodule

// File: rtl/lookahead_adder_chk.sv
module lookahead_adder_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             carry_in,
  input logic [WIDTH-1:0] sum,
  input logic             carry_out,
  input logic             grp_prop,
  input logic             grp_gen,
  input logic [WIDTH-1:0] bit_g,
  input logic [WIDTH-1:0] bit_p,
  input logic [WIDTH:0]   carry_w
);

  logic [WIDTH:0] ref_full;
  logic [WIDTH:0] ref_nocin;
  logic [WIDTH:0] low_sum;
  logic [WIDTH:0] mask;

  always_comb begin
    ref_full  = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
    ref_nocin = {1'b0, op_a} + {1'b0, op_b};

    p_sum_r1: assert (sum == ref_full[WIDTH-1:0])
      else $error("sum mismatch");
    p_cout_r2: assert (carry_out == ref_full[WIDTH])
      else $error("carry_out mismatch");
    p_prop_r3: assert (grp_prop == (&(op_a ^ op_b)))
      else $error("grp_prop mismatch");
    p_gen_r4: assert (grp_gen == ref_nocin[WIDTH])
      else $error("grp_gen mismatch");
    p_cascade_r5: assert (carry_out == (grp_gen | (grp_prop & carry_in)))
      else $error("cascade relation broken");
    p_excl_r6: assert (!(grp_gen && grp_prop))
      else $error("group gen and prop both set");

    for (int j = 1; j <= WIDTH; j++) begin
      mask    = ({{WIDTH{1'b0}}, 1'b1} << j) - {{WIDTH{1'b0}}, 1'b1};
      low_sum = ({1'b0, op_a} & mask) + ({1'b0, op_b} & mask)
              + {{WIDTH{1'b0}}, carry_in};
      p_tap_r7: assert (carry_w[j] == low_sum[j])
        else $error("internal carry %0d mismatch", j);
    end

    for (int i = 0; i < WIDTH; i++) begin
      p_class_r8: assert ($countones({bit_g[i], bit_p[i]}) <= 1
                          && (bit_g[i] | bit_p[i]) == (op_a[i] | op_b[i]))
        else $error("bit %0d classification wrong", i);
    end
  end

endmodule

bind lookahead_adder lookahead_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a     (op_a),
  .op_b     (op_b),
  .carry_in (carry_in),
  .sum      (sum),
  .carry_out(carry_out),
  .grp_prop (grp_prop),
  .grp_gen  (grp_gen),
  .bit_g    (bit_g),
  .bit_p    (bit_p),
  .carry_w  (carry_w)
);

// File: tb/lookahead_adder_tb_top.sv
`timescale 1ns/1ps
module lookahead_adder_tb_top;

  localparam int W = 8;
  localparam int NVEC = 12;
  localparam int WATCHDOG = 190000;

  logic         clk = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         carry_in = 1'b0;
  logic [W-1:0] sum;
  logic         carry_out;
  logic         grp_prop;
  logic         grp_gen;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lookahead_adder #(.WIDTH(W)) dut_i (
    .op_a     (op_a),
    .op_b     (op_b),
    .carry_in (carry_in),
    .sum      (sum),
    .carry_out(carry_out),
    .grp_prop (grp_prop),
    .grp_gen  (grp_gen)
  );

  // {a, b, cin, exp_sum, exp_cout, exp_prop, exp_gen}
  localparam logic [27:0] VEC [NVEC] = '{
    {8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
    {8'hFF, 8'h00, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0},
    {8'hFF, 8'h00, 1'b0, 8'hFF, 1'b0, 1'b1, 1'b0},
    {8'hFF, 8'h01, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1},
    {8'h80, 8'h80, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1},
    {8'h80, 8'h80, 1'b1, 8'h01, 1'b1, 1'b0, 1'b1},
    {8'h0F, 8'hF0, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0},
    {8'h55, 8'hAA, 1'b0, 8'hFF, 1'b0, 1'b1, 1'b0},
    {8'h3C, 8'h0F, 1'b0, 8'h4B, 1'b0, 1'b0, 1'b0},
    {8'hF0, 8'hCC, 1'b1, 8'hBD, 1'b1, 1'b0, 1'b1},
    {8'h7F, 8'h01, 1'b0, 8'h80, 1'b0, 1'b0, 1'b0},
    {8'hFF, 8'hFF, 1'b1, 8'hFF, 1'b1, 1'b0, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h",
               req, op_a, op_b, carry_in, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic c);
    @(posedge clk);
    op_a = a;
    op_b = b;
    carry_in = c;
    @(negedge clk);
  endtask

  task automatic check_ports(input logic [W-1:0] es, input logic ec,
                             input logic ep, input logic eg);
    chk(sum == es, "R1 sum", 32'(sum), 32'(es));
    chk(carry_out == ec, "R2 carry_out", 32'(carry_out), 32'(ec));
    chk(grp_prop == ep, "R3 grp_prop", 32'(grp_prop), 32'(ep));
    chk(grp_gen == eg, "R4 grp_gen", 32'(grp_gen), 32'(eg));
  endtask

  initial begin
    // Start-up state: zero inputs give all-zero outputs (R1, R2).
    @(negedge clk);
    check_ports(8'h00, 1'b0, 1'b0, 1'b0);

    // Vector table.
    for (int v = 0; v < NVEC; v++) begin
      apply(VEC[v][27:20], VEC[v][19:12], VEC[v][11]);
      check_ports(VEC[v][10:3], VEC[v][2], VEC[v][1], VEC[v][0]);
    end

    // R7: carry from carry_in crosses exactly j propagate bits.
    for (int j = 1; j <= W; j++) begin
      logic [W:0] ones;
      logic [W:0] exp9;
      ones = (9'd1 << j) - 9'd1;
      exp9 = 9'd1 << j;
      apply(ones[W-1:0], 8'h00, 1'b1);
      chk(sum == exp9[W-1:0], "R7 chain sum", 32'(sum), 32'(exp9[W-1:0]));
      chk(carry_out == exp9[W], "R7 chain carry_out",
          32'(carry_out), 32'(exp9[W]));
    end

    // R8: kill bits (both 0) stop a carry; mixed generate/propagate/kill.
    apply(8'h7F, 8'h00, 1'b1);
    chk(sum == 8'h80 && carry_out == 1'b0, "R8 kill at top bit",
        32'({carry_out, sum}), 32'h080);
    apply(8'hF5, 8'h0A, 1'b1);
    chk(sum == 8'h00 && carry_out == 1'b1, "R8 propagate all",
        32'({carry_out, sum}), 32'h100);
    apply(8'hEF, 8'h00, 1'b1);
    chk(sum == 8'hF0 && carry_out == 1'b0, "R8 kill at bit 4",
        32'({carry_out, sum}), 32'h0F0);

    // R9: change inputs away from any clock edge; result without an edge.
    @(posedge clk);
    #3;
    op_a = 8'h12; op_b = 8'h34; carry_in = 1'b1;
    #1;
    chk(sum == 8'h47 && carry_out == 1'b0, "R9 no clock needed",
        32'({carry_out, sum}), 32'h047);
    #2;
    op_a = 8'hC8; op_b = 8'h64; carry_in = 1'b0;
    #1;
    chk(sum == 8'h2C && carry_out == 1'b1, "R9 second change",
        32'({carry_out, sum}), 32'h12C);

    // Exhaustive sweep: R1, R2, R3, R4, R5, R6.
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        for (int c = 0; c < 2; c++) begin
          int total;
          bit ep;
          bit eg;
          apply(a[W-1:0], b[W-1:0], c[0]);
          total = a + b + c;
          ep = ((a ^ b) == 255);
          eg = ((a + b) > 255);
          if (sum != total[7:0] || carry_out != total[8]
              || grp_prop != ep || grp_gen != eg) begin
            check_ports(total[7:0], total[8], ep, eg);
          end else begin
            n_run++;
          end
          chk(carry_out == (grp_gen | (grp_prop & carry_in)),
              "R5 cascade", 32'(carry_out), 32'(eg | (ep & c[0])));
          chk(!(grp_gen && grp_prop), "R6 exclusive",
              32'({grp_gen, grp_prop}), 32'(0));
        end
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d cycles expected=<%0d", WATCHDOG,
               WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule